// File: doc/BRIEF.md
# Write-Progress Status Read Path

This block sits between a memory array, the controller that programs it and the host data bus. It decides what a host read returns. While the write controller reports that programming is under way, a read is not served from the array. It gets a status byte instead. The top bit carries the inverse of the top bit of the byte that was written last, so a host that polls the last written location sees its own data again only once programming ends. The next bit flips on every new poll, so a host that reads twice in a row can see whether the device is still busy without knowing the data. The other bits repeat the written byte. When programming is over, reads return the array data unchanged.

A read cycle starts on the first clock on which the bus-read condition holds after a clock on which it did not: chip enable low, output enable low and write enable high. Either enable, or both of them, can open a new cycle. The block also drives the enable for the data pins. The status byte is captured when the read cycle starts. It is held until the read condition goes away, so one poll returns one stable value. The bus is a plain strobe-driven interface with no back-pressure. A read cannot be stalled, and the returned byte is valid from the clock after the read starts until the cycle ends.

Top module: `eow_status_read`

## Requirements
- R1: `bus_oe` is 1 in the same cycle when `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 otherwise.
- R2: A read start is a clock edge at which the read condition of R1 holds and did not hold at the previous edge. Lowering either `ce_n` or `oe_n` can start a read, but holding the condition over several cycles counts as one read.
- R3: A read start while `busy`=1 makes `rd_data[7]` equal the complement of `last_data[7]`, with `last_data` sampled at that edge. The status byte appears from the following cycle.
- R4: The toggle state resets to 0 and inverts at each read start while `busy`=1. `rd_data[6]` of the status byte equals the toggle value after it inverts, so the first poll after reset shows 1, then 0, then 1.
- R5: In the status byte, `rd_data[5:0]` equal `last_data[5:0]` sampled at the read start.
- R6: The status byte is held for the rest of that read cycle, even if `busy` falls or `last_data` changes. It is dropped after the first edge at which the read condition is false.
- R7: When no status byte is held, `rd_data` equals `array_data` in the same cycle. A read that starts with `busy`=0 therefore returns true array data on all bits.
- R8: The toggle state is left unchanged by reads started while `busy`=0, by write strobes (`we_n`=0) and by `busy` changes. A later poll continues the alternation from where it stopped.
- R9: After reset, `rd_data` follows `array_data` and no status byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Programming in progress, from the write controller |
| last_data | input | DATA_W | Byte most recently written, from the write controller |
| array_data | input | DATA_W | Read data from the array for the current address |
| rd_data | output | DATA_W | Byte returned to the host |
| bus_oe | output | 1 | Enable for the data pin drivers |

## Verification
`bus_oe` and the array pass-through are combinational, so they are due in the same cycle as their inputs. The status byte and the toggle state change at the edge that sees a read start, and they show at the outputs from that cycle on. The bench drives inputs on the falling clock edge and compares all outputs one time unit after each rising edge. Its reference model steps its read-start, toggle and hold state at the same rising edge, so every comparison is made after all registers on the path have updated.

// File: rtl/eow_pkg.sv
package eow_pkg;
  // Default bus width of the data path.
  localparam int unsigned EOW_DATA_W = 8;

  // Read-path source selection.
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } eow_src_e;
endpackage

// File: rtl/eow_read_detect.sv
// Tracks the bus-read condition across clock edges and flags the first edge
// of each read cycle.
module eow_read_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_cond,
  output logic rd_start
);
  logic cond_q;

  assign rd_cond  = ~ce_n & ~oe_n & we_n;
  assign rd_start = rd_cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= rd_cond;
  end
endmodule

// File: rtl/eow_poll_gen.sv
// Builds the progress-status byte at each read start while busy and keeps it
// for the life of that read cycle.
module eow_poll_gen #(
  parameter int unsigned DATA_W     = eow_pkg::EOW_DATA_W,
  parameter int unsigned POLL_BIT   = DATA_W - 1,
  parameter int unsigned TOGGLE_BIT = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cond,
  input  logic              rd_start,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  output logic              tgl_q,
  output eow_pkg::eow_src_e src_q,
  output logic [DATA_W-1:0] status_q
);
  logic              tgl_nx;
  logic              poll_hit;
  logic [DATA_W-1:0] status_nx;

  assign poll_hit = rd_start & busy;
  assign tgl_nx   = ~tgl_q;

  always_comb begin
    status_nx             = last_data;
    status_nx[POLL_BIT]   = ~last_data[POLL_BIT];
    status_nx[TOGGLE_BIT] = tgl_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q    <= 1'b0;
      src_q    <= eow_pkg::SRC_ARRAY;
      status_q <= '0;
    end else if (poll_hit) begin
      tgl_q    <= tgl_nx;
      src_q    <= eow_pkg::SRC_STATUS;
      status_q <= status_nx;
    end else if (!rd_cond) begin
      src_q    <= eow_pkg::SRC_ARRAY;
    end
  end
endmodule

// File: rtl/eow_status_read.sv
// Read-data path that substitutes a progress-status byte for array data
// while programming is in progress.
module eow_status_read #(
  parameter int unsigned DATA_W = eow_pkg::EOW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_oe
);
  localparam int unsigned POLL_BIT   = DATA_W - 1;
  localparam int unsigned TOGGLE_BIT = DATA_W - 2;

  logic              rd_cond;
  logic              rd_start;
  logic              tgl_q;
  eow_pkg::eow_src_e src_q;
  logic [DATA_W-1:0] status_q;

  eow_read_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rd_cond  (rd_cond),
    .rd_start (rd_start)
  );

  eow_poll_gen #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_cond   (rd_cond),
    .rd_start  (rd_start),
    .busy      (busy),
    .last_data (last_data),
    .tgl_q     (tgl_q),
    .src_q     (src_q),
    .status_q  (status_q)
  );

  assign rd_data = (src_q == eow_pkg::SRC_STATUS) ? status_q : array_data;
  assign bus_oe  = rd_cond;
endmodule

// File: rtl/eow_status_read_chk.sv
module eow_status_read_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = DATA_W - 1,
  parameter int unsigned TOGGLE_BIT = DATA_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              busy,
  input logic [DATA_W-1:0] last_data,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              bus_oe,
  input logic              rd_start,
  input logic              tgl_q
);
  assert_poll_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT])));

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (tgl_q != $past(tgl_q)) && (rd_data[TOGGLE_BIT] == tgl_q));

  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rd_start) |=> $stable(tgl_q));

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (rd_data[TOGGLE_BIT-1:0] == $past(last_data[TOGGLE_BIT-1:0])));

  assert_status_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !rd_start && $past(bus_oe) && $past(busy && rd_start)) |=> $stable(rd_data));

  assert_true_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_start) |=> (rd_data == array_data));

  assert_bus_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !bus_oe);
endmodule

bind eow_status_read eow_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .busy       (busy),
  .last_data  (last_data),
  .array_data (array_data),
  .rd_data    (rd_data),
  .bus_oe     (bus_oe),
  .rd_start   (rd_start),
  .tgl_q      (tgl_q)
);

// File: tb/eow_status_read_tb.sv
`timescale 1ns/1ps
module eow_status_read_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_data = 8'h00, array_data = 8'h3C;
  logic [7:0] rd_data;
  logic       bus_oe;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [7:0] got;

  // behavioural reference state
  bit         m_prev = 0;
  bit         m_hold = 0;
  bit         m_tgl  = 0;
  logic [7:0] m_stat = 8'h00;

  always #2.5 clk = ~clk;

  eow_status_read u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .last_data(last_data), .array_data(array_data),
    .rd_data(rd_data), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model steps at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_hold = 0; m_tgl = 0; m_stat = 8'h00;
    end else begin
      bit cond;
      cond = !ce_n && !oe_n && we_n;
      if (cond && !m_prev && busy) begin
        m_tgl  = !m_tgl;
        m_stat = {~last_data[7], m_tgl, last_data[5:0]};
        m_hold = 1;
      end else if (!cond) begin
        m_hold = 0;
      end
      m_prev = cond;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    cycles++;
    #1;
    if (rst_n) begin
      check("R1", {7'd0, bus_oe}, {7'd0, (!ce_n && !oe_n && we_n)});
      if (m_hold) begin
        check("R3", {7'd0, rd_data[7]}, {7'd0, m_stat[7]});
        check("R4", {7'd0, rd_data[6]}, {7'd0, m_stat[6]});
        check("R5", {2'd0, rd_data[5:0]}, {2'd0, m_stat[5:0]});
      end else begin
        check("R7", rd_data, array_data);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // array data keeps changing so pass-through and hold are distinguishable
  always @(negedge clk) array_data <= array_data * 8'd5 + 8'd17;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    end
  endtask

  // one read of n cycles; returns the byte seen after the first rising edge
  task automatic poll(input int n, output logic [7:0] b);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    @(posedge clk); #1; b = rd_data;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", rd_data, array_data);
    @(negedge clk); rst_n = 1;
    idle(2);

    // read while idle: true data
    poll(3, got);
    idle(1);

    // programming active, last byte A5
    @(negedge clk); busy = 1; last_data = 8'hA5;
    poll(2, got); check("R4", got, 8'h65);
    idle(1);
    poll(2, got); check("R4", got, 8'h25);
    idle(1);
    // enable held five cycles: one poll only
    poll(5, got); check("R2", got, 8'h65);
    @(posedge clk); #1; check("R2", {7'd0, bus_oe}, 8'd0);
    idle(1);

    // busy ends inside a read: status kept until the read closes
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(posedge clk); #1; check("R3", got & 8'h00, 8'h00);
    check("R3", {7'd0, rd_data[7]}, 8'd0);
    @(negedge clk); busy = 0; last_data = 8'h11;
    @(posedge clk); #1; check("R6", rd_data, 8'h25);
    @(negedge clk); oe_n = 1;
    @(posedge clk); #1; check("R6", rd_data, array_data);
    idle(1);

    // idle reads and write strobes do not move the toggle
    poll(2, got);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk); busy = 1; last_data = 8'h4E;
    @(negedge clk); busy = 0;
    idle(2);
    @(negedge clk); busy = 1; last_data = 8'h4E;
    poll(2, got); check("R8", got, 8'hCE);
    idle(1);

    // start via chip enable while output enable already low
    @(negedge clk); oe_n = 0; ce_n = 1;
    @(negedge clk); ce_n = 0;
    @(posedge clk); #1; check("R2", rd_data, 8'h8E);
    @(negedge clk); ce_n = 1;
    // start via output enable while chip enable already low
    @(negedge clk); ce_n = 0; oe_n = 1;
    @(negedge clk); oe_n = 0;
    @(posedge clk); #1; check("R2", rd_data, 8'hCE);
    idle(2);
    @(negedge clk); busy = 0;
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule